// File: doc/BRIEF.md
# DRAM Refresh Command Sequencer

This block sits on the controller side of a low-power DDR-type SDRAM. It turns three simple requests into the exact pin sequences needed for an auto refresh, or for entering and leaving self refresh. The first request starts an auto refresh. The second asks the device to enter self refresh. The third asks it to leave self refresh. The block drives chip select, row strobe, column strobe, write enable, the all-banks address flag, CKE and an enable for the memory clock. It also reports busy and in-self-refresh status to the upstream arbiter.

Every refresh path begins with a precharge of all banks. Each minimum spacing is counted in controller clocks. The spacings are: precharge to refresh, refresh to next activate or refresh, self-refresh residency, clock-stable lead before CKE rises, and CKE rise to first activate. Each spacing comes from a parameter. While busy is high, the arbiter must issue no command of its own. Once busy falls, any activate it issues already satisfies the refresh and exit spacings.

In self refresh the memory clock is gated off and CKE is held low. On exit, the clock is restored first while NOP is driven. Only after the lead time does CKE rise.

Top module: `dram_rfsh_seq`

## Requirements
- R1: While reset is held and afterwards with no request, the outputs are the idle state: NOP (cs_n=0, ras_n=1, cas_n=1, we_n=1), ap=0, cke=1, mclk_en=1, busy=0, in_sr=0.
- R2: A refresh request sampled while idle makes the next cycle a precharge-all: cs_n=0, ras_n=0, cas_n=1, we_n=0 with ap=1, and busy rises in that same cycle.
- R3: The auto refresh command (cs_n=0, ras_n=0, cas_n=0, we_n=1, cke=1) appears exactly T_RP cycles after the precharge-all. NOP is driven in the cycles between them.
- R4: After the auto refresh command, NOP is driven and busy stays high for T_RFC-1 cycles. In the cycle T_RFC after the refresh, the block is back in the idle state of R1.
- R5: A self-refresh request sampled while idle gives a precharge-all. T_RP cycles later comes the entry command: cs_n=0, ras_n=0, cas_n=0, we_n=1 with cke=0, while mclk_en is still 1.
- R6: From the cycle after the entry command until exit, mclk_en=0, cke=0, in_sr=1, busy=1, and the pins carry deselect (cs_n=ras_n=cas_n=we_n=1) with the default SR_DESELECT=1.
- R7: An exit request is acted on only after T_RFC-1 cycles of residency have passed. An earlier exit pulse has no effect. An exit level that is already high is honoured at the first cycle it is allowed.
- R8: After an exit is accepted, in_sr falls, mclk_en returns to 1, and NOP is driven with cke=0 for T_CKSTABLE cycles. Only then does cke rise.
- R9: Once cke rises, NOP is driven and busy stays high for T_XSR cycles. After that the block is in the idle state.
- R10: A refresh or self-refresh request arriving while busy is ignored. An exit request outside self refresh is ignored.
- R11: When a refresh request and a self-refresh request arrive in the same idle cycle, the auto refresh is performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ar_req_i | input | 1 | Start one auto refresh |
| sr_enter_i | input | 1 | Enter self refresh |
| sr_exit_i | input | 1 | Leave self refresh (level) |
| busy_o | output | 1 | Sequence in progress; arbiter must hold off |
| in_sr_o | output | 1 | Device resident in self refresh |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| ap_o | output | 1 | All-banks address bit for precharge |
| cke_o | output | 1 | Clock enable to the memory |
| mclk_en_o | output | 1 | Enable for the memory clock driver |

## Verification
The auto-refresh path is exercised four ways: alone, with refresh and self-refresh requests injected during its recovery window, with an exit request while idle, and with both start requests arriving together. These runs separate correct spacing from correct ignoring and from correct priority. The self-refresh path is run twice. In the first run the exit level is already high, which shows that residency alone sets the earliest exit. In the second run the hold is long, with an early exit pulse and a refresh pulse inside it. This shows that early requests leave the held state untouched and that a late exit gives the same clock-restore and CKE-rise timing.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_AR_PRE,
      ST_AR_RP,
      ST_AR_REF,
      ST_AR_RFC,
      ST_SR_PRE,
      ST_SR_RP,
      ST_SR_ENT,
      ST_SR_HOLD,
      ST_SR_CLK,
      ST_SR_XSR
   } rfsh_state_e;

   typedef enum logic [1:0] {
      CMD_NOP,
      CMD_PRE_ALL,
      CMD_REFRESH,
      CMD_PARK
   } rfsh_cmd_e;

   typedef struct packed {
      logic cs_n;
      logic ras_n;
      logic cas_n;
      logic we_n;
      logic ap;
   } rfsh_pins_t;

   function automatic int unsigned max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/rfsh_dly_cnt.sv
module rfsh_dly_cnt #(
   parameter int unsigned CW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic [CW-1:0] load_val_i,
   output logic          done_o
);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load_i) begin
         cnt_q <= load_val_i;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - CW'(1);
      end
   end

   assign done_o = (cnt_q == '0);

endmodule

// File: rtl/rfsh_cmd_enc.sv
module rfsh_cmd_enc
   import rfsh_pkg::*;
#(
   parameter bit PARK_DESELECT = 1'b1
) (
   input  rfsh_cmd_e  cmd_i,
   output rfsh_pins_t pins_o
);

   rfsh_pins_t park_pins;

   generate
      if (PARK_DESELECT) begin : g_park_desel
         assign park_pins = '{cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1, ap: 1'b0};
      end else begin : g_park_nop
         assign park_pins = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1, ap: 1'b0};
      end
   endgenerate

   always_comb begin
      unique case (cmd_i)
         CMD_PRE_ALL: pins_o = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0, ap: 1'b1};
         CMD_REFRESH: pins_o = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1, ap: 1'b0};
         CMD_PARK:    pins_o = park_pins;
         default:     pins_o = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1, ap: 1'b0};
      endcase
   end

endmodule

// File: rtl/dram_rfsh_seq.sv
module dram_rfsh_seq
   import rfsh_pkg::*;
#(
   parameter int unsigned T_RP        = 3,
   parameter int unsigned T_RFC       = 10,
   parameter int unsigned T_XSR       = 12,
   parameter int unsigned T_CKSTABLE  = 2,
   parameter bit          SR_DESELECT = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ar_req_i,
   input  logic sr_enter_i,
   input  logic sr_exit_i,
   output logic busy_o,
   output logic in_sr_o,
   output logic cs_n_o,
   output logic ras_n_o,
   output logic cas_n_o,
   output logic we_n_o,
   output logic ap_o,
   output logic cke_o,
   output logic mclk_en_o
);

   localparam int unsigned MAX_DLY = max2(max2(T_RP, T_RFC), max2(T_XSR, T_CKSTABLE));
   localparam int unsigned CW      = $clog2(MAX_DLY + 1);

   localparam logic [CW-1:0] LD_RP  = CW'(T_RP - 2);
   localparam logic [CW-1:0] LD_RFC = CW'(T_RFC - 2);
   localparam logic [CW-1:0] LD_CKS = CW'(T_CKSTABLE - 1);
   localparam logic [CW-1:0] LD_XSR = CW'(T_XSR - 1);

   generate
      if (T_RP < 2) begin : g_bad_rp
         $error("T_RP must be at least 2");
      end
      if (T_RFC < 2) begin : g_bad_rfc
         $error("T_RFC must be at least 2");
      end
      if (T_XSR < 1) begin : g_bad_xsr
         $error("T_XSR must be at least 1");
      end
      if (T_CKSTABLE < 1) begin : g_bad_cks
         $error("T_CKSTABLE must be at least 1");
      end
   endgenerate

   rfsh_state_e   state_q, state_d;
   logic          dly_done;
   logic          dly_load;
   logic [CW-1:0] dly_val;
   rfsh_cmd_e     cmd;
   rfsh_pins_t    pins;

   // next-state selection; each wait state leaves only when its window is spent
   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE: begin
            if (ar_req_i)        state_d = ST_AR_PRE;
            else if (sr_enter_i) state_d = ST_SR_PRE;
         end
         ST_AR_PRE:  state_d = ST_AR_RP;
         ST_AR_RP:   if (dly_done) state_d = ST_AR_REF;
         ST_AR_REF:  state_d = ST_AR_RFC;
         ST_AR_RFC:  if (dly_done) state_d = ST_IDLE;
         ST_SR_PRE:  state_d = ST_SR_RP;
         ST_SR_RP:   if (dly_done) state_d = ST_SR_ENT;
         ST_SR_ENT:  state_d = ST_SR_HOLD;
         ST_SR_HOLD: if (dly_done && sr_exit_i) state_d = ST_SR_CLK;
         ST_SR_CLK:  if (dly_done) state_d = ST_SR_XSR;
         ST_SR_XSR:  if (dly_done) state_d = ST_IDLE;
         default:    state_d = ST_IDLE;
      endcase
   end

   // window length armed on every state change, chosen by the state being entered
   always_comb begin
      dly_load = (state_d != state_q);
      unique case (state_d)
         ST_AR_RP, ST_SR_RP:    dly_val = LD_RP;
         ST_AR_RFC, ST_SR_HOLD: dly_val = LD_RFC;
         ST_SR_CLK:             dly_val = LD_CKS;
         ST_SR_XSR:             dly_val = LD_XSR;
         default:               dly_val = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end

   rfsh_dly_cnt #(
      .CW (CW)
   ) u_dly (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (dly_load),
      .load_val_i (dly_val),
      .done_o     (dly_done)
   );

   always_comb begin
      unique case (state_q)
         ST_AR_PRE, ST_SR_PRE: cmd = CMD_PRE_ALL;
         ST_AR_REF, ST_SR_ENT: cmd = CMD_REFRESH;
         ST_SR_HOLD:           cmd = CMD_PARK;
         default:              cmd = CMD_NOP;
      endcase
   end

   rfsh_cmd_enc #(
      .PARK_DESELECT (SR_DESELECT)
   ) u_enc (
      .cmd_i  (cmd),
      .pins_o (pins)
   );

   assign cs_n_o    = pins.cs_n;
   assign ras_n_o   = pins.ras_n;
   assign cas_n_o   = pins.cas_n;
   assign we_n_o    = pins.we_n;
   assign ap_o      = pins.ap;
   assign cke_o     = !(state_q inside {ST_SR_ENT, ST_SR_HOLD, ST_SR_CLK});
   assign mclk_en_o = (state_q != ST_SR_HOLD);
   assign busy_o    = (state_q != ST_IDLE);
   assign in_sr_o   = (state_q == ST_SR_HOLD);

endmodule

// File: rtl/dram_rfsh_seq_chk.sv
module dram_rfsh_seq_chk #(
   parameter int unsigned T_RP       = 3,
   parameter int unsigned T_RFC      = 10,
   parameter int unsigned T_CKSTABLE = 2
) (
   input logic clk,
   input logic rst_n,
   input logic busy_o,
   input logic in_sr_o,
   input logic cs_n_o,
   input logic ras_n_o,
   input logic cas_n_o,
   input logic we_n_o,
   input logic cke_o,
   input logic mclk_en_o
);

   logic        is_pre, is_ref, is_sre;
   logic [15:0] since_pre_q, since_ref_q, since_sre_q, clk_run_q;

   assign is_pre = !cs_n_o && !ras_n_o &&  cas_n_o && !we_n_o;
   assign is_ref = !cs_n_o && !ras_n_o && !cas_n_o &&  we_n_o;
   assign is_sre = is_ref && !cke_o;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         since_pre_q <= '0;
         since_ref_q <= '1;
         since_sre_q <= '1;
         clk_run_q   <= '0;
      end else begin
         if (is_pre) since_pre_q <= 16'd1;
         else if (since_pre_q != '1) since_pre_q <= since_pre_q + 16'd1;
         if (is_ref) since_ref_q <= 16'd1;
         else if (since_ref_q != '1) since_ref_q <= since_ref_q + 16'd1;
         if (is_sre) since_sre_q <= 16'd1;
         else if (since_sre_q != '1) since_sre_q <= since_sre_q + 16'd1;
         if (!mclk_en_o) clk_run_q <= '0;
         else if (clk_run_q != '1) clk_run_q <= clk_run_q + 16'd1;
      end
   end

   AST_REF_AFTER_PRE: assert property (@(posedge clk) disable iff (!rst_n)
      is_ref |-> since_pre_q >= 16'(T_RP)); // R3

   AST_REF_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
      is_ref |-> since_ref_q >= 16'(T_RFC)); // R4

   AST_REF_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (is_ref || is_pre) |-> busy_o); // R2

   AST_ENTRY_CKE_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      is_sre |-> $past(cke_o) && mclk_en_o); // R5

   AST_CLOCK_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !mclk_en_o |-> !cke_o && ras_n_o && cas_n_o && we_n_o && in_sr_o); // R6

   AST_RESIDENCY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cke_o) |-> since_sre_q >= 16'(T_RFC)); // R7

   AST_CLOCK_LEAD: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cke_o) |-> clk_run_q >= 16'(T_CKSTABLE)); // R8

   AST_SR_FLAG_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      in_sr_o |-> busy_o && !cke_o); // R6

endmodule

bind dram_rfsh_seq dram_rfsh_seq_chk #(
   .T_RP       (T_RP),
   .T_RFC      (T_RFC),
   .T_CKSTABLE (T_CKSTABLE)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .busy_o    (busy_o),
   .in_sr_o   (in_sr_o),
   .cs_n_o    (cs_n_o),
   .ras_n_o   (ras_n_o),
   .cas_n_o   (cas_n_o),
   .we_n_o    (we_n_o),
   .cke_o     (cke_o),
   .mclk_en_o (mclk_en_o)
);

// File: tb/dram_rfsh_seq_tb_top.sv
`timescale 1ns/1ps
module dram_rfsh_seq_tb_top;

   localparam int TRP  = 3;
   localparam int TRFC = 8;
   localparam int TXSR = 4;
   localparam int TCKS = 2;

   // {cs_n, ras_n, cas_n, we_n}
   localparam logic [3:0] C_NOP = 4'b0111;
   localparam logic [3:0] C_PRE = 4'b0010;
   localparam logic [3:0] C_REF = 4'b0001;
   localparam logic [3:0] C_DES = 4'b1111;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ar_req = 1'b0, sr_enter = 1'b0, sr_exit = 1'b0;
   logic busy, in_sr, cs_n, ras_n, cas_n, we_n, ap, cke, mclk_en;

   int n_cmp = 0;
   int n_fail = 0;
   logic [8:0] exp_q[$];
   string      tag_q[$];

   always #2.5 clk = ~clk;

   dram_rfsh_seq #(
      .T_RP (TRP), .T_RFC (TRFC), .T_XSR (TXSR), .T_CKSTABLE (TCKS), .SR_DESELECT (1'b1)
   ) dut_i (
      .clk (clk), .rst_n (rst_n),
      .ar_req_i (ar_req), .sr_enter_i (sr_enter), .sr_exit_i (sr_exit),
      .busy_o (busy), .in_sr_o (in_sr),
      .cs_n_o (cs_n), .ras_n_o (ras_n), .cas_n_o (cas_n), .we_n_o (we_n),
      .ap_o (ap), .cke_o (cke), .mclk_en_o (mclk_en)
   );

   function automatic logic [8:0] ev(input logic [3:0] c, input logic a, input logic k,
                                     input logic ce, input logic b, input logic s);
      return {b, s, c, a, k, ce};
   endfunction

   task automatic push(input logic [8:0] v, input string tag);
      exp_q.push_back(v);
      tag_q.push_back(tag);
   endtask

   task automatic push_idle(input int n, input string tag);
      for (int i = 0; i < n; i++) push(ev(C_NOP, 0, 1, 1, 0, 0), tag);
   endtask

   task automatic exp_ar(input string pre_tag, input string tail_tag);
      push(ev(C_PRE, 1, 1, 1, 1, 0), pre_tag);                              // R2
      for (int i = 1; i < TRP; i++) push(ev(C_NOP, 0, 1, 1, 1, 0), "R3");
      push(ev(C_REF, 0, 1, 1, 1, 0), "R3");
      for (int i = 1; i < TRFC; i++) push(ev(C_NOP, 0, 1, 1, 1, 0), tail_tag); // R4 window
      push_idle(1, tail_tag);
   endtask

   task automatic exp_sr(input int hold, input string hold_tag);
      push(ev(C_PRE, 1, 1, 1, 1, 0), "R5");
      for (int i = 1; i < TRP; i++) push(ev(C_NOP, 0, 1, 1, 1, 0), "R5");
      push(ev(C_REF, 0, 0, 1, 1, 0), "R5");
      for (int i = 0; i < hold; i++) push(ev(C_DES, 0, 0, 0, 1, 1), hold_tag); // R6
      for (int i = 0; i < TCKS; i++) push(ev(C_NOP, 0, 0, 1, 1, 0), "R8");
      for (int i = 0; i < TXSR; i++) push(ev(C_NOP, 0, 1, 1, 1, 0), "R9");
      push_idle(1, "R9");
   endtask

   task automatic drain();
      while (exp_q.size() != 0) @(negedge clk);
   endtask

   // monitor: one expected item per cycle, sampled 1 ns after the edge
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (exp_q.size() != 0) begin
            logic [8:0] e, a;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            a = {busy, in_sr, cs_n, ras_n, cas_n, we_n, ap, cke, mclk_en};
            n_cmp++;
            if (a !== e) begin
               n_fail++;
               $display("FAIL %s: got %b expected %b (busy,in_sr,cs,ras,cas,we,ap,cke,clken)", t, a, e);
            end
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: got hang expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state seen at the pins while reset is held
      n_cmp++;
      if ({busy, in_sr, cs_n, ras_n, cas_n, we_n, ap, cke, mclk_en} !== ev(C_NOP, 0, 1, 1, 0, 0)) begin
         n_fail++;
         $display("FAIL R1: got %b expected %b",
                  {busy, in_sr, cs_n, ras_n, cas_n, we_n, ap, cke, mclk_en}, ev(C_NOP, 0, 1, 1, 0, 0));
      end
      rst_n = 1'b1;
      push_idle(3, "R1");
      drain();

      // plain auto refresh: R2, R3, R4
      exp_ar("R2", "R4");
      ar_req = 1'b1;
      @(negedge clk); ar_req = 1'b0;
      drain();

      // requests injected during recovery, incl. the last busy cycle: R10
      exp_ar("R2", "R10");
      ar_req = 1'b1;
      for (int c = 1; c <= TRP + TRFC; c++) begin
         @(negedge clk);
         ar_req   = (c == TRP + 2) || (c == TRP + TRFC);
         sr_enter = (c == TRP + 2);
      end
      @(negedge clk); ar_req = 1'b0; sr_enter = 1'b0;
      drain();

      // exit request while idle has no effect: R10
      push_idle(4, "R10");
      sr_exit = 1'b1;
      repeat (2) @(negedge clk);
      sr_exit = 1'b0;
      drain();

      // simultaneous requests: auto refresh wins, R11
      exp_ar("R11", "R4");
      ar_req = 1'b1; sr_enter = 1'b1;
      @(negedge clk); ar_req = 1'b0; sr_enter = 1'b0;
      drain();

      // self refresh with exit already high: earliest exit, R7
      exp_sr(TRFC - 1, "R7");
      sr_enter = 1'b1;
      @(negedge clk); sr_enter = 1'b0; sr_exit = 1'b1;
      drain();
      sr_exit = 1'b0;

      // long hold with early exit and refresh pulses ignored: R6, R7, R10
      exp_sr(TRFC + 3, "R6");
      sr_enter = 1'b1;
      for (int c = 1; c <= TRP + 1 + TRFC + 3; c++) begin
         @(negedge clk);
         sr_enter = 1'b0;
         sr_exit  = (c == TRP + 3) || (c == TRP + 1 + TRFC + 3);
         ar_req   = (c == TRP + 4);
      end
      @(negedge clk); sr_exit = 1'b0; ar_req = 1'b0;
      drain();

      // refresh straight after self refresh: R2
      exp_ar("R2", "R4");
      ar_req = 1'b1;
      @(negedge clk); ar_req = 1'b0;
      drain();

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
      $finish;
   end

endmodule